// File: doc/BRIEF.md
# Byte-Addressed Access Bridge for a Row-Only SRAM

This block turns byte-addressed 8-, 16- and 32-bit reads and writes into cycles on a 32-bit single-port synchronous SRAM. The SRAM has no byte enables, so each SRAM cycle reads or writes a whole row. The SRAM sits inside the block. A request may start at any byte address. The block runs the shortest sequence of whole-row cycles that serves it. Writes that touch only part of a row use read-modify-write. A read that crosses a row boundary fetches both rows and returns the bytes as one right-justified word.

A strict-alignment input turns on abort mode. In abort mode, a request whose address is not a multiple of its size gets an error response in the cycle after acceptance, and the SRAM is not touched. The request side uses valid/ready and serves one request at a time. The response is a one-cycle strobe that carries read data and an error flag.

Top module: `ua_sram_bridge`

## Requirements
- R1: Size encoding on `req_size` is 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. Lanes are little-endian: the byte at address 4N+k is bits 8k+7..8k of row N, where the row index is the byte address divided by four. Read data is right-justified and zero-extended above the requested size.
- R2: A 32-bit write to an address that is a multiple of four is one SRAM write with no read. Its response strobe appears 2 clock edges after the acceptance edge, counting that edge.
- R3: A read that stays within one row (any 8-bit read, a 16-bit read at offset 0..2, a 32-bit read at offset 0) returns its data 3 edges after acceptance.
- R4: A read that crosses into the next row (a 16-bit read at offset 3, a 32-bit read at offset 1..3) reads both rows and returns the merged value in one response, 4 edges after acceptance.
- R5: A write of fewer than four bytes that stays within one row reads the row, replaces only the addressed bytes, and writes the row back. The response comes 3 edges after acceptance, and all other bytes keep their values.
- R6: A write that crosses into the next row does a read-modify-write on both rows, one row after the other, for four SRAM cycles in total. The response comes 5 edges after acceptance, and the bytes it does not address keep their values.
- R7: An access that crosses the end of the last row continues at row 0.
- R8: When `abort_misaligned` is 1, a 16-bit request with address bit 0 set, or a 32-bit request whose two low address bits are not both zero, gets `rsp_err` = 1 one edge after acceptance, and memory is left unchanged. Aligned requests and all 8-bit requests are served normally in this mode.
- R9: `req_ready` is low from the edge after acceptance until the response strobe. Responses to served requests carry `rsp_err` = 0.
- R10: After reset, `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_misaligned | input | 1 | 1 = reject misaligned requests with an error |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| req_addr | input | ROW_AW+2 | Byte address |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request was rejected as misaligned |
| rsp_rdata | output | 32 | Read data, right-justified, zero-extended |

## Verification
A lane error or a shift error shows up as a wrong byte at the first read that covers the affected address. A write that merges the wrong lanes or the wrong row corrupts a neighbouring byte. That corruption stays hidden until a later read of that neighbour, so every write scenario reads back the whole surrounding region. A state machine that takes a wrong branch changes the number of edges between acceptance and the response strobe, and the bench sees this on the same transfer. A faulty abort check shows either as an error flag that should not be there or as bytes that changed in memory.

// File: rtl/ua_bridge_pkg.sv
package ua_bridge_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_WFULL = 3'd1,
    S_RDA   = 3'd2,
    S_MRGA  = 3'd3,
    S_RDB   = 3'd4,
    S_MRGB  = 3'd5
  } seq_state_e;

endpackage

// File: rtl/ua_word_ram.sv
module ua_word_ram #(
  parameter int ROW_AW = 6,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_AW-1:0] addr,
  input  logic [DW-1:0]     wd,
  output logic [DW-1:0]     q
);
  localparam int DEPTH = 1 << ROW_AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    q <= mem[addr];
  end
endmodule

// File: rtl/ua_lane_merge.sv
module ua_lane_merge
  import ua_bridge_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [$clog2(DW/8)-1:0] off,
  input  logic [1:0]              size,
  input  logic [DW-1:0]           wdata,
  input  logic                    hi_sel,
  input  logic [DW-1:0]           row_q,
  input  logic [DW-1:0]           lo_word,
  input  logic [DW-1:0]           hi_word,
  output logic [DW-1:0]           wr_row,
  output logic [DW-1:0]           rd_word,
  output logic                    spans
);
  localparam int NL   = DW / 8;
  localparam int OFFW = $clog2(NL);

  logic [NL-1:0]   lane_en;
  logic [2*NL-1:0] mask2;
  logic [2*DW-1:0] wd2;
  logic [2*DW-1:0] rd2;
  logic [OFFW+2:0] shamt;

  always_comb begin
    case (size)
      SZ_BYTE: lane_en = NL'(1);
      SZ_HALF: lane_en = NL'(3);
      default: lane_en = '1;
    endcase
    shamt = {off, 3'b000};
    mask2 = {{NL{1'b0}}, lane_en} << off;
    wd2   = {{DW{1'b0}}, wdata} << shamt;
    rd2   = {hi_word, lo_word} >> shamt;
    spans = |mask2[2*NL-1:NL];
  end

  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic       sel;
    logic [7:0] nb;
    always_comb begin
      sel = hi_sel ? mask2[NL+k] : mask2[k];
      nb  = hi_sel ? wd2[DW+8*k +: 8] : wd2[8*k +: 8];
    end
    assign wr_row[8*k +: 8]  = sel ? nb : row_q[8*k +: 8];
    assign rd_word[8*k +: 8] = lane_en[k] ? rd2[8*k +: 8] : 8'h00;
  end
endmodule

// File: rtl/ua_sram_bridge.sv
module ua_sram_bridge
  import ua_bridge_pkg::*;
#(
  parameter int ROW_AW = 6,
  parameter int DW     = 32,
  localparam int NL    = DW / 8,
  localparam int OFFW  = $clog2(NL),
  localparam int AW    = ROW_AW + OFFW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort_misaligned,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata
);
  seq_state_e        state;
  logic              r_write;
  logic [1:0]        r_size;
  logic [ROW_AW-1:0] r_row;
  logic [OFFW-1:0]   r_off;
  logic [DW-1:0]     r_wdata;
  logic [DW-1:0]     hold_lo;

  logic              accept, misal, reject, full_wr;
  logic [OFFW-1:0]   in_off;
  logic [ROW_AW-1:0] row_b, ram_addr;
  logic              ram_we;
  logic [DW-1:0]     ram_wd, ram_q;
  logic [DW-1:0]     mrg_row, mrg_rd, lo_word, hi_word;
  logic              spans, hi_sel;

  assign req_ready = (state == S_IDLE);
  assign in_off    = req_addr[OFFW-1:0];
  assign accept    = req_valid && req_ready;
  assign misal     = ((req_size == SZ_HALF) && req_addr[0]) ||
                     ((req_size != SZ_BYTE) && (req_size != SZ_HALF) && (in_off != '0));
  assign reject    = accept && abort_misaligned && misal;
  assign full_wr   = req_write && (req_size != SZ_BYTE) && (req_size != SZ_HALF) &&
                     (in_off == '0);

  assign row_b    = r_row + ROW_AW'(1);
  assign ram_addr = ((state == S_RDB) || (state == S_MRGB) ||
                     ((state == S_MRGA) && !r_write)) ? row_b : r_row;
  assign ram_we   = (state == S_WFULL) ||
                    (r_write && ((state == S_MRGA) || (state == S_MRGB)));
  assign ram_wd   = (state == S_WFULL) ? r_wdata : mrg_row;

  assign hi_sel  = (state == S_MRGB);
  assign lo_word = hi_sel ? hold_lo : ram_q;
  assign hi_word = hi_sel ? ram_q : '0;

  ua_word_ram #(.ROW_AW(ROW_AW), .DW(DW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .addr (ram_addr),
    .wd   (ram_wd),
    .q    (ram_q)
  );

  ua_lane_merge #(.DW(DW)) u_merge (
    .off     (r_off),
    .size    (r_size),
    .wdata   (r_wdata),
    .hi_sel  (hi_sel),
    .row_q   (ram_q),
    .lo_word (lo_word),
    .hi_word (hi_word),
    .wr_row  (mrg_row),
    .rd_word (mrg_rd),
    .spans   (spans)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (reject) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
          end else if (accept) begin
            state <= full_wr ? S_WFULL : S_RDA;
          end
        end
        S_WFULL: begin
          rsp_valid <= 1'b1;
          rsp_rdata <= '0;
          state     <= S_IDLE;
        end
        S_RDA: state <= S_MRGA;
        S_MRGA: begin
          if (spans) begin
            state <= r_write ? S_RDB : S_MRGB;
          end else begin
            rsp_valid <= 1'b1;
            rsp_rdata <= r_write ? '0 : mrg_rd;
            state     <= S_IDLE;
          end
        end
        S_RDB: state <= S_MRGB;
        S_MRGB: begin
          rsp_valid <= 1'b1;
          rsp_rdata <= r_write ? '0 : mrg_rd;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      r_write <= req_write;
      r_size  <= req_size;
      r_row   <= req_addr[AW-1:OFFW];
      r_off   <= in_off;
      r_wdata <= req_wdata;
    end
    if (state == S_MRGA) hold_lo <= ram_q;
  end

  // R8: a rejected request answers at once with an error and no SRAM write
  p_reject_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    reject |=> (rsp_valid && rsp_err && !ram_we));

  // R8: an error flag only follows a cycle with abort mode on
  p_err_needs_abort_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(abort_misaligned));

  // R2: an aligned word write is one write, then the response
  p_full_write_once_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && full_wr) |=> (ram_we ##1 (rsp_valid && !ram_we)));

  // R9: a response appears only when the bridge is idle again
  p_rsp_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

  // R6: two SRAM writes never come in consecutive cycles
  p_no_back_to_back_we_r6: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);

  // R5: every merged write is preceded by the read of its row
  p_rmw_after_read_r5: assert property (@(posedge clk) disable iff (rst)
    (ram_we && (state != S_WFULL)) |->
      (($past(state) == S_RDA) || ($past(state) == S_RDB)));
endmodule

// File: tb/ua_sram_bridge_bench.sv
module ua_sram_bridge_bench;
  localparam int RAW = 6;
  localparam int AW  = RAW + 2;
  localparam int NB  = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        abort_misaligned = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_mem [NB];

  ua_sram_bridge #(.ROW_AW(RAW), .DW(32)) u_ua_sram_bridge (
    .clk(clk), .rst(rst), .abort_misaligned(abort_misaligned),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit is_misal(input logic [1:0] sz, input int a);
    return ((sz == 2'd1) && (a % 2 != 0)) || ((sz == 2'd2) && (a % 4 != 0));
  endfunction

  function automatic int exp_lat(input bit wr, input logic [1:0] sz, input int a,
                                 input bit strict);
    bit sp;
    if (strict && is_misal(sz, a)) return 1;
    sp = ((a % 4) + nbytes(sz)) > 4;
    if (wr && sz == 2'd2 && (a % 4 == 0)) return 2;
    if (!wr) return sp ? 4 : 3;
    return sp ? 5 : 3;
  endfunction

  task automatic xfer(input bit wr, input logic [1:0] sz, input int a,
                      input logic [31:0] wd, input bit strict, input string tag);
    int lat;
    int el;
    bit ee;
    logic [31:0] exp_rd;
    el = exp_lat(wr, sz, a, strict);
    ee = strict && is_misal(sz, a);
    exp_rd = '0;
    for (int i = 0; i < nbytes(sz); i++)
      exp_rd[8*i +: 8] = ref_mem[(a + i) % NB];
    @(negedge clk);
    abort_misaligned = strict;
    req_write = wr; req_size = sz; req_addr = AW'(a); req_wdata = wd;
    req_valid = 1'b1;
    chk(req_ready === 1'b1, "R9", "ready before request", {31'b0, req_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (!ee)
      chk(req_ready === 1'b0, "R9", "ready while busy", {31'b0, req_ready}, 32'd0);
    while (rsp_valid !== 1'b1 && lat < 12) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    chk(lat == el, tag, "response latency", 32'(lat), 32'(el));
    chk(rsp_err === ee, ee ? "R8" : "R9", "error flag", {31'b0, rsp_err}, {31'b0, ee});
    if (!wr && !ee)
      chk(rsp_rdata === exp_rd, tag, "read data", rsp_rdata, exp_rd);
    if (wr && !ee)
      for (int i = 0; i < nbytes(sz); i++)
        ref_mem[(a + i) % NB] = wd[8*i +: 8];
  endtask

  task automatic verify_region(input int a0, input int a1, input string tag);
    for (int a = a0; a <= a1; a += 4)
      xfer(1'b0, 2'd2, (a & ~3) % NB, 32'h0, 1'b0, tag);
  endtask

  task automatic t_reset;
    chk(req_ready === 1'b1, "R10", "ready after reset", {31'b0, req_ready}, 32'd1);
    chk(rsp_valid === 1'b0, "R10", "no response after reset", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_fill;
    for (int r = 0; r < NB / 4; r++) begin
      logic [31:0] w;
      for (int k = 0; k < 4; k++) w[8*k +: 8] = 8'((4*r + k) * 37 + 11);
      xfer(1'b1, 2'd2, 4*r, w, 1'b0, "R2");
    end
  endtask

  task automatic t_aligned_reads;
    for (int r = 0; r < NB / 4; r += 5) xfer(1'b0, 2'd2, 4*r, 0, 1'b0, "R1");
  endtask

  task automatic t_narrow_reads;
    for (int o = 0; o < 4; o++) xfer(1'b0, 2'd0, 40 + o, 0, 1'b0, "R3");
    for (int o = 0; o < 3; o++) xfer(1'b0, 2'd1, 48 + o, 0, 1'b0, "R3");
    xfer(1'b0, 2'd1, 51, 0, 1'b0, "R4");
  endtask

  task automatic t_word_unaligned_reads;
    for (int o = 1; o < 4; o++) xfer(1'b0, 2'd2, 60 + o, 0, 1'b0, "R4");
  endtask

  task automatic t_partial_writes;
    xfer(1'b1, 2'd0, 81, 32'hFFFF_FFA5, 1'b0, "R5");
    xfer(1'b1, 2'd1, 85, 32'hDEAD_C3B2, 1'b0, "R5");
    xfer(1'b1, 2'd1, 90, 32'h0000_7E19, 1'b0, "R5");
    verify_region(76, 96, "R5");
  endtask

  task automatic t_span_writes;
    xfer(1'b1, 2'd1, 103, 32'h0000_E1D2, 1'b0, "R6");
    xfer(1'b1, 2'd2, 110, 32'h8765_4321, 1'b0, "R6");
    xfer(1'b1, 2'd2, 117, 32'hCAFE_F00D, 1'b0, "R6");
    verify_region(96, 124, "R6");
  endtask

  task automatic t_wrap;
    xfer(1'b0, 2'd2, NB - 3, 0, 1'b0, "R7");
    xfer(1'b1, 2'd2, NB - 1, 32'h1122_3344, 1'b0, "R7");
    xfer(1'b0, 2'd1, NB - 1, 0, 1'b0, "R7");
    verify_region(NB - 4, NB - 1, "R7");
    verify_region(0, 3, "R7");
  endtask

  task automatic t_abort;
    xfer(1'b1, 2'd1, 131, 32'h0000_BEEF, 1'b1, "R8");
    xfer(1'b1, 2'd2, 138, 32'h5555_AAAA, 1'b1, "R8");
    xfer(1'b0, 2'd2, 141, 0, 1'b1, "R8");
    verify_region(128, 144, "R8");
    xfer(1'b1, 2'd0, 133, 32'h0000_0077, 1'b1, "R8");
    xfer(1'b1, 2'd1, 134, 32'h0000_9A8B, 1'b1, "R8");
    xfer(1'b0, 2'd2, 132, 0, 1'b1, "R8");
    xfer(1'b0, 2'd2, 141, 0, 1'b0, "R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R9 actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_aligned_reads();
    t_narrow_reads();
    t_word_unaligned_reads();
    t_partial_writes();
    t_span_writes();
    t_wrap();
    t_abort();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule